// File: doc/BRIEF.md
# Single-Wire Bus Time-Slot Master

This block is the timing layer of a host controller for an open-drain, single-data-line bus whose idle level is high. A host hands it one request at a time: a bus reset with presence detection, a byte write, a byte read, a single-bit read, or a strong-pullup hold. The block turns each request into timed low pulses on `bus_drive_low`, samples the synchronised bus level, and returns the result. Device addressing, search and CRC checks are left to the layers above.

Each bit is carried by the width of a low pulse inside a fixed-length slot. The master samples the line in a short window after it releases the line. All timing is counted in microseconds from a tick derived from `CLK_HZ`. A write request can ask for a strong pullup straight after its last bit. During a hold, `spu_en` tells the board to drive the line hard to the rail, and the block drives no low pulse.

The request side uses valid/ready. `req_ready` is low while `busy` is high, and a request offered then is not taken. The host must keep `req_valid` and its fields steady until it sees `req_ready` high at a clock edge. An op code outside the five listed values is taken and then dropped. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse, and `rsp_data` holds its value until the next response.

Top module: `sw_slot_master`

## Requirements
- R1: A reset request (op 0) drives the line low for exactly 480 µs, then releases it. The whole reset sequence occupies at least 960 µs.
- R2: After a reset, the bus is sampled 70 µs after release. A low level there sets `presence` to 1 and `rsp_data[0]` to 1. A high level sets both to 0, and `rsp_data[7:1]` is 0.
- R3: A written 1 is a low pulse of exactly 6 µs, and a written 0 is a low pulse of exactly 60 µs.
- R4: A write request (op 1) sends the 8 bits of `req_data` least significant bit first.
- R5: Consecutive slot starts are at least 70 µs apart, and the line is released for at least 1 µs between slots.
- R6: A byte read (op 2) issues 8 slots, each with a 3 µs low pulse. It samples 10 µs after each falling edge and assembles `rsp_data` least significant bit first.
- R7: A bit read (op 3) issues a single read slot and returns the sampled level in `rsp_data[0]`, with the other bits 0.
- R8: A hold request (op 4) raises `spu_en` for exactly `req_hold_us` µs. The line is never driven low while `spu_en` is high.
- R9: A write with `req_hold_after` set raises `spu_en` no later than 10 µs after the end of the 70 µs last slot, and holds it for `req_hold_us` µs.
- R10: `busy` rises only when a request is accepted and stays high until the last slot and its recovery time are over. A request offered while busy is ignored.
- R11: `rsp_valid` pulses for one cycle at the end of a reset, a byte read or a bit read, in the cycle that `busy` falls. Writes and holds produce no pulse.
- R12: While `busy` is low, the line is released and `spu_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at `CLK_HZ` |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (not busy) |
| req_op | input | 3 | 0 reset, 1 write byte, 2 read byte, 3 read bit, 4 hold |
| req_data | input | 8 | Byte to write |
| req_hold_after | input | 1 | Write only: strong pullup after the last bit |
| req_hold_us | input | HOLD_W | Strong-pullup duration in µs |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | 8 | Read data, or presence in bit 0 |
| busy | output | 1 | A request is in progress |
| presence | output | 1 | Result of the latest reset |
| bus_in | input | 1 | Bus level as seen at the pin |
| bus_drive_low | output | 1 | Open-drain pull-down enable |
| spu_en | output | 1 | Strong-pullup enable |

## Verification
The bench models a slave that answers resets, measures every low pulse in cycles, and decodes the written bits from those widths. An off-by-one microsecond counter shows up as a pulse 4 cycles too long or too short. A reversed shift shows up as a mirrored byte. A missing recovery gap shows up as back-to-back slots. A hold that overlaps a drive pulse, or that starts late after a write, is caught by timing the `spu_en` edge against the last slot start. A request pushed in the middle of a byte must leave the pulse count, the bit values and the response count unchanged; a design that took it would add slots or emit a stray response.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic [2:0] {
    OP_RESET     = 3'd0,
    OP_WRITE     = 3'd1,
    OP_READ_BYTE = 3'd2,
    OP_READ_BIT  = 3'd3,
    OP_HOLD      = 3'd4
  } sw_op_e;

  typedef enum logic [2:0] {
    SK_RESET = 3'd0,
    SK_W0    = 3'd1,
    SK_W1    = 3'd2,
    SK_READ  = 3'd3,
    SK_HOLD  = 3'd4
  } slot_kind_e;
endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sw_us_tick.sv
module sw_us_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)    cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST) && !clr;
endmodule

// File: rtl/sw_slot_engine.sv
module sw_slot_engine
  import sw_pkg::*;
#(
  parameter int RST_LOW    = 480,
  parameter int RST_LISTEN = 480,
  parameter int PRES_SAMP  = 70,
  parameter int W1_LOW     = 6,
  parameter int W0_LOW     = 60,
  parameter int RD_LOW     = 3,
  parameter int RD_SAMP    = 10,
  parameter int SLOT       = 70,
  parameter int REC        = 2,
  parameter int HOLD_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  slot_kind_e        kind,
  input  logic [HOLD_W-1:0] hold_us,
  input  logic              tick,
  input  logic              bus_s,
  output logic              drive_low,
  output logic              spu_en,
  output logic              done,
  output logic              bit_val
);
  localparam int T_RST  = RST_LOW + RST_LISTEN;
  localparam int T_HOLD = (1 << HOLD_W) + REC;
  localparam int T_MAX  = (T_RST > T_HOLD) ? T_RST : T_HOLD;
  localparam int UW     = $clog2(T_MAX + 1);

  logic              active;
  slot_kind_e        kind_q;
  logic [UW-1:0]     us;
  logic [HOLD_W-1:0] hold_q;
  logic [UW-1:0]     low_len, total, samp_at;
  logic              samp_en;

  always_comb begin
    low_len = '0;
    total   = UW'(SLOT + REC);
    samp_en = 1'b0;
    samp_at = '0;
    case (kind_q)
      SK_RESET: begin
        low_len = UW'(RST_LOW);
        total   = UW'(T_RST);
        samp_en = 1'b1;
        samp_at = UW'(RST_LOW + PRES_SAMP);
      end
      SK_W0:   low_len = UW'(W0_LOW);
      SK_W1:   low_len = UW'(W1_LOW);
      SK_READ: begin
        low_len = UW'(RD_LOW);
        samp_en = 1'b1;
        samp_at = UW'(RD_SAMP);
      end
      SK_HOLD: total = UW'(hold_q) + UW'(REC);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      kind_q  <= SK_RESET;
      us      <= '0;
      hold_q  <= '0;
      done    <= 1'b0;
      bit_val <= 1'b1;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        kind_q <= kind;
        us     <= '0;
        hold_q <= hold_us;
      end else if (active && tick) begin
        if (samp_en && (us == samp_at - 1'b1)) bit_val <= bus_s;
        if (us == total - 1'b1) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          us <= us + 1'b1;
        end
      end
    end
  end

  assign drive_low = active && (us < low_len);
  assign spu_en    = active && (kind_q == SK_HOLD) && (us < UW'(hold_q));
endmodule

// File: rtl/sw_byte_seq.sv
module sw_byte_seq
  import sw_pkg::*;
#(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [7:0]        req_data,
  input  logic              req_hold_after,
  input  logic [HOLD_W-1:0] req_hold_us,
  output logic              req_ready,
  output logic              eng_start,
  output slot_kind_e        eng_kind,
  output logic [HOLD_W-1:0] eng_hold_us,
  input  logic              eng_done,
  input  logic              eng_bit,
  output logic              busy,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              presence
);
  logic       run;
  sw_op_e     op_q;
  logic [7:0] sh, rx;
  logic [2:0] cnt;
  logic       hold_after, in_hold;
  logic       accept, op_ok, last_bit;
  logic [7:0] rx_n, sh_n;

  assign busy      = run;
  assign req_ready = !run;
  assign op_ok     = (req_op <= 3'd4);
  assign accept    = req_valid && !run;
  assign last_bit  = (op_q == OP_READ_BIT) || (cnt == 3'd7);
  assign rx_n      = {eng_bit, rx[7:1]};
  assign sh_n      = {1'b0, sh[7:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run         <= 1'b0;
      op_q        <= OP_RESET;
      sh          <= '0;
      rx          <= '0;
      cnt         <= '0;
      hold_after  <= 1'b0;
      in_hold     <= 1'b0;
      eng_start   <= 1'b0;
      eng_kind    <= SK_RESET;
      eng_hold_us <= '0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      presence    <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      rsp_valid <= 1'b0;
      if (accept && op_ok) begin
        run         <= 1'b1;
        op_q        <= sw_op_e'(req_op);
        sh          <= req_data;
        rx          <= '0;
        cnt         <= '0;
        hold_after  <= (req_op == OP_WRITE) && req_hold_after;
        in_hold     <= (req_op == OP_HOLD);
        eng_hold_us <= req_hold_us;
        eng_start   <= 1'b1;
        case (sw_op_e'(req_op))
          OP_RESET:     eng_kind <= SK_RESET;
          OP_WRITE:     eng_kind <= req_data[0] ? SK_W1 : SK_W0;
          OP_READ_BYTE,
          OP_READ_BIT:  eng_kind <= SK_READ;
          default:      eng_kind <= SK_HOLD;
        endcase
      end else if (run && eng_done) begin
        if (op_q == OP_RESET) begin
          run       <= 1'b0;
          presence  <= !eng_bit;
          rsp_valid <= 1'b1;
          rsp_data  <= {7'd0, !eng_bit};
        end else if (in_hold) begin
          run <= 1'b0;
        end else if (op_q == OP_WRITE) begin
          sh  <= sh_n;
          cnt <= cnt + 1'b1;
          if (cnt != 3'd7) begin
            eng_start <= 1'b1;
            eng_kind  <= sh_n[0] ? SK_W1 : SK_W0;
          end else if (hold_after) begin
            in_hold   <= 1'b1;
            eng_start <= 1'b1;
            eng_kind  <= SK_HOLD;
          end else begin
            run <= 1'b0;
          end
        end else begin
          rx  <= rx_n;
          cnt <= cnt + 1'b1;
          if (last_bit) begin
            run       <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_data  <= (op_q == OP_READ_BIT) ? {7'd0, eng_bit} : rx_n;
          end else begin
            eng_start <= 1'b1;
            eng_kind  <= SK_READ;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sw_slot_master.sv
module sw_slot_master
  import sw_pkg::*;
#(
  parameter int CLK_HZ        = 50_000_000,
  parameter int RST_LOW_US    = 480,
  parameter int RST_LISTEN_US = 480,
  parameter int PRES_SAMP_US  = 70,
  parameter int W1_LOW_US     = 6,
  parameter int W0_LOW_US     = 60,
  parameter int RD_LOW_US     = 3,
  parameter int RD_SAMP_US    = 10,
  parameter int SLOT_US       = 70,
  parameter int REC_US        = 2,
  parameter int HOLD_W        = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [7:0]        req_data,
  input  logic              req_hold_after,
  input  logic [HOLD_W-1:0] req_hold_us,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              busy,
  output logic              presence,
  input  logic              bus_in,
  output logic              bus_drive_low,
  output logic              spu_en
);
  localparam int DIV = CLK_HZ / 1_000_000;

  logic              bus_s, tick, eng_start, eng_done, eng_bit;
  slot_kind_e        eng_kind;
  logic [HOLD_W-1:0] eng_hold_us;

  sw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_in), .q(bus_s)
  );

  sw_us_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(eng_start), .tick(tick)
  );

  sw_slot_engine #(
    .RST_LOW(RST_LOW_US), .RST_LISTEN(RST_LISTEN_US), .PRES_SAMP(PRES_SAMP_US),
    .W1_LOW(W1_LOW_US), .W0_LOW(W0_LOW_US), .RD_LOW(RD_LOW_US),
    .RD_SAMP(RD_SAMP_US), .SLOT(SLOT_US), .REC(REC_US), .HOLD_W(HOLD_W)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .kind(eng_kind),
    .hold_us(eng_hold_us), .tick(tick), .bus_s(bus_s),
    .drive_low(bus_drive_low), .spu_en(spu_en), .done(eng_done), .bit_val(eng_bit)
  );

  sw_byte_seq #(.HOLD_W(HOLD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_data(req_data), .req_hold_after(req_hold_after), .req_hold_us(req_hold_us),
    .req_ready(req_ready), .eng_start(eng_start), .eng_kind(eng_kind),
    .eng_hold_us(eng_hold_us), .eng_done(eng_done), .eng_bit(eng_bit),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .presence(presence)
  );
endmodule

// File: rtl/sw_slot_master_chk.sv
module sw_slot_master_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic rsp_valid,
  input logic bus_drive_low,
  input logic spu_en
);
  p_spu_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_drive_low && spu_en));

  p_idle_released_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_drive_low && !spu_en));

  p_busy_on_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready));

  p_rsp_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_at_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!busy && $past(busy)));
endmodule

bind sw_slot_master sw_slot_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .rsp_valid(rsp_valid), .bus_drive_low(bus_drive_low), .spu_en(spu_en)
);

// File: tb/sw_slot_master_tb.sv
module sw_slot_master_tb;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [7:0]  req_data = '0;
  logic        req_hold_after = 1'b0;
  logic [15:0] req_hold_us = '0;
  logic        rsp_valid, busy, presence, bus_drive_low, spu_en;
  logic [7:0]  rsp_data;
  logic        bus_in;
  logic        slave_low = 1'b0;

  always #2 clk = ~clk;

  assign bus_in = !(bus_drive_low || slave_low);

  sw_slot_master #(.CLK_HZ(DIV * 1_000_000)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_data(req_data), .req_hold_after(req_hold_after),
    .req_hold_us(req_hold_us), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(busy), .presence(presence), .bus_in(bus_in),
    .bus_drive_low(bus_drive_low), .spu_en(spu_en)
  );

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  // monitor / slave model state
  int cyc = 0, pstart = 0, prelease = 0, npulse = 0, min_gap = 0;
  int widths[16];
  int starts[16];
  int low_from = 0, low_until = 0;
  bit slave_present = 0, slave_rd = 0;
  logic [7:0] tx_byte = '0;
  int tx_idx = 0;
  int spu_rise = 0, spu_w = 0, spu_rises = 0, busy_cnt = 0;
  int rsp_cnt = 0;
  logic [7:0] last_rsp = '0;
  logic prev_dl = 0, prev_spu = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (busy) busy_cnt++;
      if (bus_drive_low && !prev_dl) begin
        if (npulse > 0 && (cyc - prelease) < min_gap) min_gap = cyc - prelease;
        if (npulse < 16) starts[npulse] = cyc;
        pstart = cyc;
        if (slave_rd) begin
          if (!tx_byte[tx_idx[2:0]]) begin low_from = cyc; low_until = cyc + 15 * DIV; end
          tx_idx++;
        end
      end
      if (!bus_drive_low && prev_dl) begin
        if (npulse < 16) widths[npulse] = cyc - pstart;
        npulse++;
        prelease = cyc;
        if ((cyc - pstart) >= 400 * DIV && slave_present) begin
          low_from = cyc + 15 * DIV; low_until = cyc + 135 * DIV;
        end
      end
      slave_low = (cyc >= low_from) && (cyc < low_until);
      if (spu_en && !prev_spu) begin spu_rise = cyc; spu_rises++; end
      if (spu_en) spu_w++;
      if (spu_en && bus_drive_low) begin
        n_chk++; n_fail++;
        $display("FAIL R8 actual=1 expected=0 (drive during hold)");
      end
      if (rsp_valid) begin rsp_cnt++; last_rsp = rsp_data; end
      prev_dl = bus_drive_low;
      prev_spu = spu_en;
    end
  end

  task automatic clear_mon();
    @(negedge clk);
    npulse = 0; min_gap = 1 << 30; tx_idx = 0;
    spu_w = 0; spu_rises = 0; rsp_cnt = 0; busy_cnt = 0;
  endtask

  task automatic do_req(input logic [2:0] op, input logic [7:0] d,
                        input logic ha, input logic [15:0] hu);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = op; req_data = d; req_hold_after = ha; req_hold_us = hu;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] decode_write();
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[i] = (widths[i] < 15 * DIV);
    return b;
  endfunction

  task automatic t_reset_state();
    chk(busy == 0, "R10 busy after reset", busy, 0);
    chk(req_ready == 1, "R10 ready after reset", req_ready, 1);
    chk(bus_drive_low == 0 && spu_en == 0, "R12 line released", bus_drive_low, 0);
    chk(presence == 0, "R2 presence at reset", presence, 0);
  endtask

  task automatic t_bus_reset(input bit present);
    slave_present = present; slave_rd = 0;
    clear_mon();
    do_req(3'd0, 8'h00, 0, 0);
    wait_idle();
    chk(npulse == 1, "R1 one reset pulse", npulse, 1);
    chk(widths[0] == 480 * DIV, "R1 reset low width", widths[0], 480 * DIV);
    chk(busy_cnt >= 960 * DIV, "R1 reset duration", busy_cnt, 960 * DIV);
    chk(presence == present, "R2 presence flag", presence, present);
    chk(rsp_cnt == 1, "R11 reset response count", rsp_cnt, 1);
    chk(last_rsp == {7'd0, present}, "R2 reset rsp_data", last_rsp, present);
  endtask

  task automatic t_write(input logic [7:0] b);
    slave_present = 0; slave_rd = 0;
    clear_mon();
    do_req(3'd1, b, 0, 0);
    wait_idle();
    chk(npulse == 8, "R4 write slot count", npulse, 8);
    for (int i = 0; i < 8; i++)
      chk(widths[i] == (b[i] ? 6 : 60) * DIV, "R3 write pulse width", widths[i],
          (b[i] ? 6 : 60) * DIV);
    chk(decode_write() == b, "R4 LSB-first byte", decode_write(), b);
    for (int i = 0; i < 7; i++)
      chk(starts[i+1] - starts[i] >= 70 * DIV, "R5 slot spacing",
          starts[i+1] - starts[i], 70 * DIV);
    chk(min_gap >= DIV, "R5 recovery gap", min_gap, DIV);
    chk(rsp_cnt == 0, "R11 no response on write", rsp_cnt, 0);
  endtask

  task automatic t_read_byte(input logic [7:0] b);
    slave_rd = 1; tx_byte = b;
    clear_mon();
    do_req(3'd2, 8'h00, 0, 0);
    wait_idle();
    slave_rd = 0;
    chk(npulse == 8, "R6 read slot count", npulse, 8);
    for (int i = 0; i < 8; i++)
      chk(widths[i] == 3 * DIV, "R6 read init width", widths[i], 3 * DIV);
    chk(rsp_cnt == 1, "R11 read response count", rsp_cnt, 1);
    chk(last_rsp == b, "R6 read data", last_rsp, b);
  endtask

  task automatic t_read_bit(input bit v);
    slave_rd = 1; tx_byte = {8{v}};
    clear_mon();
    do_req(3'd3, 8'h00, 0, 0);
    wait_idle();
    slave_rd = 0;
    chk(npulse == 1, "R7 single slot", npulse, 1);
    chk(last_rsp == {7'd0, v}, "R7 bit value", last_rsp, v);
    chk(rsp_cnt == 1, "R11 bit response count", rsp_cnt, 1);
  endtask

  task automatic t_hold(input int dur);
    clear_mon();
    do_req(3'd4, 8'h00, 0, dur[15:0]);
    wait_idle();
    chk(spu_w == dur * DIV, "R8 hold width", spu_w, dur * DIV);
    chk(npulse == 0, "R8 no drive in hold", npulse, 0);
    chk(rsp_cnt == 0, "R11 no response on hold", rsp_cnt, 0);
  endtask

  task automatic t_write_hold(input logic [7:0] b, input int dur);
    slave_rd = 0;
    clear_mon();
    do_req(3'd1, b, 1, dur[15:0]);
    wait_idle();
    chk(decode_write() == b, "R9 byte before hold", decode_write(), b);
    chk(spu_rises == 1, "R9 one hold", spu_rises, 1);
    chk(spu_rise - starts[7] <= 80 * DIV, "R9 hold start delay", spu_rise - starts[7], 80 * DIV);
    chk(spu_rise > starts[7] + 70 * DIV - 1, "R9 hold after slot", spu_rise - starts[7], 70 * DIV);
    chk(spu_w == dur * DIV, "R9 hold width", spu_w, dur * DIV);
  endtask

  task automatic t_busy_ignore();
    slave_rd = 0;
    clear_mon();
    do_req(3'd1, 8'hFF, 0, 0);
    repeat (100) @(negedge clk);
    chk(req_ready == 0 && busy == 1, "R10 ready low while busy", req_ready, 0);
    req_valid = 1; req_op = 3'd2;
    @(negedge clk);
    req_valid = 0;
    wait_idle();
    repeat (40) @(negedge clk);
    chk(npulse == 8, "R10 extra request ignored", npulse, 8);
    chk(decode_write() == 8'hFF, "R10 byte intact", decode_write(), 8'hFF);
    chk(rsp_cnt == 0, "R10 no stray response", rsp_cnt, 0);
    chk(busy == 0, "R10 idle afterwards", busy, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_bus_reset(1);
    t_bus_reset(0);
    t_write(8'hA5);
    t_write(8'h01);
    t_read_byte(8'h3C);
    t_read_byte(8'hF0);
    t_read_bit(0);
    t_read_bit(1);
    t_hold(50);
    t_write_hold(8'h44, 30);
    t_busy_ignore();
    finish_run();
  end
endmodule